// File: doc/BRIEF.md
# Five-State Snooping Cache Line Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Each line carries one of five states: Invalid, Shared, Exclusive, Recent (the single clean copy that answers other caches' read misses) and Modified. Processor loads and stores arrive on a valid/ready request channel. Hits that need no bus action complete locally. Everything else becomes a bus transaction: read, read-for-ownership, invalidate or dirty writeback.

The same controller watches every transaction that other caches place on the bus. A snooped read that finds the line clean in Exclusive or Recent is answered cache-to-cache. If it finds the line Modified, the data is also answered cache-to-cache, and a memory-update strobe is raised in the same transaction. In both cases the supplier falls back to Shared, and the requester installs the line in Recent. This moves the forwarding role to the newest sharer. Snooped ownership requests and invalidates knock the line out. Arbitration, main memory and victim selection belong to the surrounding system: the victim is always the line at the index the address selects.

Back-pressure rules: a processor request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Ready is low while a miss or upgrade is in flight and on any cycle that carries a snoop. The response is a one-cycle pulse with no back-pressure. A bus request stays valid until the cycle the bus grants it with `bus_req_ready`. Its completion arrives later as a one-cycle `bus_rsp_valid` pulse, except for writebacks, which complete on the grant. The snoop outputs answer combinationally in the cycle that `snp_valid` is high.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address goes to the bus; right after reset `cpu_req_ready` is 1 and `bus_req_valid`, `cpu_rsp_valid` and all snoop outputs are 0.
- R2: A read that hits a valid line produces no bus request, and `cpu_rsp_valid` pulses in the cycle after acceptance with the line's data.
- R3: A write that hits an Exclusive or Modified line completes without any bus request and leaves the line Modified.
- R4: A write that hits a Shared or Recent line first issues an invalidate (command code 2). It becomes Modified only when that completes, and every other copy becomes Invalid.
- R5: A read miss issues a read (code 0). The line fills into Recent when a peer supplied the data. It fills into Shared when a peer held it without supplying, and into Exclusive otherwise.
- R6: A snooped read (code 0) that hits Exclusive or Recent raises `snp_hit` and `snp_supply` with the line data, leaves `snp_mem_wr` low, and drops the line to Shared.
- R7: A snooped read that hits Modified supplies the data, raises `snp_mem_wr`, and drops the line to Shared.
- R8: A snooped read-for-ownership (code 1) or invalidate (code 2) that hits any valid state leaves the line Invalid. A Modified holder supplies the data with `snp_mem_wr`. An Exclusive or Recent holder answering a read-for-ownership supplies clean data.
- R9: A snooped read that hits a Shared line raises `snp_hit` but not `snp_supply`.
- R10: A write miss issues a read-for-ownership (code 1), and the line ends Modified holding the written data.
- R11: A miss whose indexed line is Modified under another tag first issues a writeback (code 3) carrying the victim's address and data, and only then issues the miss request.
- R12: `bus_req_valid` holds until granted. `cpu_req_ready` is low while a bus request is outstanding and on every snoop cycle.
- R13: Across caches, every read returns the value of the most recent write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data (store data echoed for stores) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Grant; transaction is placed on the bus |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Writeback data |
| bus_rsp_valid | input | 1 | Completion of a read, ownership or invalidate request |
| bus_rsp_rdata | input | DATA_W | Fill data |
| bus_rsp_supplied | input | 1 | A peer answered with data |
| bus_rsp_shared | input | 1 | A peer held a valid copy |
| snp_valid | input | 1 | Peer transaction being snooped |
| snp_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache answers with data |
| snp_mem_wr | output | 1 | Memory must take the supplied data |
| snp_rdata | output | DATA_W | Supplied data |

## Verification
On every cycle, the assertions check the handshake rules. They also check that a snoop which supplied or invalidated a line cannot hit the same way again one cycle later, and that every processor response is caused by an acceptance or a bus completion. The state a fill lands in, which cache supplies the data, whether memory is updated, and the order of writeback before a miss can only be shown by the bench. Its two-cache scenarios are compared against a behavioural model of both caches and memory. Coherent read-back across caches also rests on those scenarios.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_R = 3'd3,
    LS_M = 3'd4
  } line_state_e;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RFO  = 2'd1,
    BC_INV  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  function automatic line_state_e fill_state(input logic supplied, input logic shared);
    if (supplied)    return LS_R;
    else if (shared) return LS_S;
    else             return LS_E;
  endfunction

  function automatic logic can_write_silently(input line_state_e s);
    return (s == LS_E) || (s == LS_M);
  endfunction
endpackage

// File: rtl/slc_line_array.sv
module slc_line_array
  import slc_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_state_e       a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_state_e       b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_state_e       sw_state,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_state_e       cw_state,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [DATA_W-1:0] cw_data
);
  logic [LINES*ST_W-1:0]   st_vec;
  logic [LINES*TAG_W-1:0]  tag_vec;
  logic [LINES*DATA_W-1:0] dat_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_state_e       st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              cw_sel;
    logic              sw_sel;

    assign cw_sel = cw_en && (cw_idx == IDX_W'(i));
    assign sw_sel = sw_en && (sw_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_I;
        tag_q <= '0;
        dat_q <= '0;
      end else if (cw_sel) begin
        st_q  <= cw_state;
        tag_q <= cw_tag;
        dat_q <= cw_data;
      end else if (sw_sel) begin
        st_q  <= sw_state;
      end
    end

    assign st_vec[i*ST_W +: ST_W]     = st_q;
    assign tag_vec[i*TAG_W +: TAG_W]  = tag_q;
    assign dat_vec[i*DATA_W +: DATA_W] = dat_q;
  end

  assign a_state = line_state_e'(st_vec[int'(a_idx)*ST_W +: ST_W]);
  assign a_tag   = tag_vec[int'(a_idx)*TAG_W +: TAG_W];
  assign a_data  = dat_vec[int'(a_idx)*DATA_W +: DATA_W];
  assign b_state = line_state_e'(st_vec[int'(b_idx)*ST_W +: ST_W]);
  assign b_tag   = tag_vec[int'(b_idx)*TAG_W +: TAG_W];
  assign b_data  = dat_vec[int'(b_idx)*DATA_W +: DATA_W];
endmodule

// File: rtl/slc_snoop_unit.sv
module slc_snoop_unit
  import slc_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_state_e       line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              hit,
  output logic              supply,
  output logic              mem_wr,
  output logic [DATA_W-1:0] rdata,
  output logic              upd,
  output line_state_e       next_state
);
  bus_cmd_e cmd;
  logic     owner_clean;

  assign cmd         = bus_cmd_e'(snp_cmd);
  assign owner_clean = (line_state == LS_E) || (line_state == LS_R);

  always_comb begin
    hit        = snp_valid && (cmd != BC_WB) && (line_state != LS_I) && (line_tag == snp_tag);
    supply     = 1'b0;
    mem_wr     = 1'b0;
    upd        = 1'b0;
    next_state = line_state;
    if (hit) begin
      unique case (cmd)
        BC_READ: begin
          if (line_state == LS_M) begin
            supply = 1'b1;
            mem_wr = 1'b1;
          end else if (owner_clean) begin
            supply = 1'b1;
          end
          upd        = 1'b1;
          next_state = LS_S;
        end
        BC_RFO: begin
          supply     = (line_state == LS_M) || owner_clean;
          mem_wr     = (line_state == LS_M);
          upd        = 1'b1;
          next_state = LS_I;
        end
        BC_INV: begin
          supply     = (line_state == LS_M);
          mem_wr     = (line_state == LS_M);
          upd        = 1'b1;
          next_state = LS_I;
        end
        default: begin
          upd = 1'b0;
        end
      endcase
    end
    rdata = supply ? line_data : '0;
  end
endmodule

// File: rtl/slc_req_fsm.sv
module slc_req_fsm
  import slc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_state_e       lk_state,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              cw_en,
  output line_state_e       cw_state,
  output logic [TAG_W-1:0]  cw_tag,
  output logic [DATA_W-1:0] cw_data,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              bus_rsp_supplied,
  input  logic              bus_rsp_shared
);
  typedef enum logic [1:0] {FS_IDLE, FS_BUS, FS_WAIT} fsm_e;

  fsm_e              fs_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_hit;
  logic              victim_dirty;
  logic              accept;
  logic              fast_hit;
  logic              grant;
  logic              fill_done;
  bus_cmd_e          cmd;

  assign cur_addr = (fs_q == FS_IDLE) ? cpu_req_addr : op_addr_q;
  assign lk_idx   = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];

  assign tag_hit      = (lk_state != LS_I) && (lk_tag == cur_tag);
  assign victim_dirty = (lk_state == LS_M) && (lk_tag != cur_tag);

  assign cpu_req_ready = (fs_q == FS_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign fast_hit      = tag_hit && (!cpu_req_write || can_write_silently(lk_state));

  // The command is derived from the live line state until the grant, so a
  // snoop that steals the line while waiting turns an upgrade into a full
  // ownership request, and a victim cleaned by a snoop needs no writeback.
  always_comb begin
    if (victim_dirty)  cmd = BC_WB;
    else if (!op_wr_q) cmd = BC_READ;
    else if (tag_hit)  cmd = BC_INV;
    else               cmd = BC_RFO;
  end

  assign bus_req_valid = (fs_q == FS_BUS);
  assign bus_req_cmd   = cmd;
  assign bus_req_addr  = (cmd == BC_WB) ? {lk_tag, lk_idx} : op_addr_q;
  assign bus_req_wdata = (cmd == BC_WB) ? lk_data : '0;
  assign grant         = bus_req_valid && bus_req_ready;
  assign fill_done     = (fs_q == FS_WAIT) && bus_rsp_valid;

  always_comb begin
    cw_en    = 1'b0;
    cw_state = lk_state;
    cw_tag   = lk_tag;
    cw_data  = lk_data;
    if (accept && fast_hit && cpu_req_write) begin
      cw_en    = 1'b1;
      cw_state = LS_M;
      cw_data  = cpu_req_wdata;
    end else if (grant && (cmd == BC_WB)) begin
      cw_en    = 1'b1;
      cw_state = LS_I;
    end else if (fill_done) begin
      cw_en    = 1'b1;
      cw_tag   = cur_tag;
      cw_state = op_wr_q ? LS_M : fill_state(bus_rsp_supplied, bus_rsp_shared);
      cw_data  = op_wr_q ? op_wdata_q : bus_rsp_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q       <= FS_IDLE;
      op_wr_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
    end else begin
      unique case (fs_q)
        FS_IDLE: begin
          if (accept && !fast_hit) begin
            fs_q       <= FS_BUS;
            op_wr_q    <= cpu_req_write;
            op_addr_q  <= cpu_req_addr;
            op_wdata_q <= cpu_req_wdata;
          end
        end
        FS_BUS: begin
          if (grant && (cmd != BC_WB)) fs_q <= FS_WAIT;
        end
        FS_WAIT: begin
          if (bus_rsp_valid) fs_q <= FS_IDLE;
        end
        default: fs_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= (accept && fast_hit) || fill_done;
      if (accept && fast_hit)
        rsp_d_q <= cpu_req_write ? cpu_req_wdata : lk_data;
      else if (fill_done)
        rsp_d_q <= op_wr_q ? op_wdata_q : bus_rsp_rdata;
    end
  end

  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_d_q;
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import slc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              bus_rsp_supplied,
  input  logic              bus_rsp_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic              snp_mem_wr,
  output logic [DATA_W-1:0] snp_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  line_state_e       lk_state;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              cw_en;
  line_state_e       cw_state;
  logic [TAG_W-1:0]  cw_tag;
  logic [DATA_W-1:0] cw_data;

  logic [IDX_W-1:0]  sn_idx;
  line_state_e       sn_state;
  logic [TAG_W-1:0]  sn_tag;
  logic [DATA_W-1:0] sn_data;
  logic              sn_upd;
  line_state_e       sn_next;

  assign sn_idx = snp_addr[IDX_W-1:0];

  slc_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_idx), .a_state(lk_state), .a_tag(lk_tag), .a_data(lk_data),
    .b_idx(sn_idx), .b_state(sn_state), .b_tag(sn_tag), .b_data(sn_data),
    .sw_en(sn_upd), .sw_idx(sn_idx), .sw_state(sn_next),
    .cw_en(cw_en), .cw_idx(lk_idx), .cw_state(cw_state), .cw_tag(cw_tag), .cw_data(cw_data)
  );

  slc_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_state(sn_state), .line_tag(sn_tag), .line_data(sn_data),
    .hit(snp_hit), .supply(snp_supply), .mem_wr(snp_mem_wr), .rdata(snp_rdata),
    .upd(sn_upd), .next_state(sn_next)
  );

  slc_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .snp_valid(snp_valid),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_tag(lk_tag), .lk_data(lk_data),
    .cw_en(cw_en), .cw_state(cw_state), .cw_tag(cw_tag), .cw_data(cw_data),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
    .bus_rsp_supplied(bus_rsp_supplied), .bus_rsp_shared(bus_rsp_shared)
  );
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_rsp_valid,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_hit,
  input logic              snp_supply
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid) else $error("request dropped"); // R12
  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready) else $error("ready during snoop"); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready) else $error("ready while bus busy"); // R12
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> ($past(cpu_req_valid && cpu_req_ready) || $past(bus_rsp_valid)))
    else $error("response without cause"); // R2
  AST_SUPPLY_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd0 && snp_supply) |=>
    !(snp_valid && snp_cmd == 2'd0 && snp_addr == $past(snp_addr) && snp_supply))
    else $error("supplier kept forwarding role"); // R6
  AST_OWNERSHIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2) && snp_hit) |=>
    !(snp_valid && snp_addr == $past(snp_addr) && snp_hit))
    else $error("line survived ownership snoop"); // R8
endmodule

bind snoop_line_ctrl slc_checker #(.ADDR_W(ADDR_W)) u_slc_checker (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_rsp_valid(bus_rsp_valid),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_hit(snp_hit), .snp_supply(snp_supply)
);

// File: tb/snoop_line_ctrl_bench.sv
`timescale 1ns/100ps
module snoop_line_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 8;
  localparam int SI = 0, SS = 1, SE = 2, SR = 3, SM = 4;
  localparam int CRD = 0, CRFO = 1, CINV = 2, CWB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          rq_v[2], rq_rdy[2], rq_w[2];
  logic [AW-1:0] rq_a[2];
  logic [DW-1:0] rq_d[2];
  logic          rs_v[2];
  logic [DW-1:0] rs_d[2];
  logic          br_v[2], br_rdy[2];
  logic [1:0]    br_cmd[2];
  logic [AW-1:0] br_a[2];
  logic [DW-1:0] br_d[2];
  logic          bp_v[2], bp_sup[2], bp_sh[2];
  logic [DW-1:0] bp_d[2];
  logic          sn_v[2];
  logic [1:0]    sn_cmd[2];
  logic [AW-1:0] sn_a[2];
  logic          sn_hit[2], sn_sup[2], sn_mw[2];
  logic [DW-1:0] sn_d[2];

  snoop_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_snoop_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(rq_v[0]), .cpu_req_ready(rq_rdy[0]), .cpu_req_write(rq_w[0]),
    .cpu_req_addr(rq_a[0]), .cpu_req_wdata(rq_d[0]),
    .cpu_rsp_valid(rs_v[0]), .cpu_rsp_rdata(rs_d[0]),
    .bus_req_valid(br_v[0]), .bus_req_ready(br_rdy[0]), .bus_req_cmd(br_cmd[0]),
    .bus_req_addr(br_a[0]), .bus_req_wdata(br_d[0]),
    .bus_rsp_valid(bp_v[0]), .bus_rsp_rdata(bp_d[0]), .bus_rsp_supplied(bp_sup[0]), .bus_rsp_shared(bp_sh[0]),
    .snp_valid(sn_v[0]), .snp_cmd(sn_cmd[0]), .snp_addr(sn_a[0]),
    .snp_hit(sn_hit[0]), .snp_supply(sn_sup[0]), .snp_mem_wr(sn_mw[0]), .snp_rdata(sn_d[0])
  );

  snoop_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_snoop_line_ctrl_peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(rq_v[1]), .cpu_req_ready(rq_rdy[1]), .cpu_req_write(rq_w[1]),
    .cpu_req_addr(rq_a[1]), .cpu_req_wdata(rq_d[1]),
    .cpu_rsp_valid(rs_v[1]), .cpu_rsp_rdata(rs_d[1]),
    .bus_req_valid(br_v[1]), .bus_req_ready(br_rdy[1]), .bus_req_cmd(br_cmd[1]),
    .bus_req_addr(br_a[1]), .bus_req_wdata(br_d[1]),
    .bus_rsp_valid(bp_v[1]), .bus_rsp_rdata(bp_d[1]), .bus_rsp_supplied(bp_sup[1]), .bus_rsp_shared(bp_sh[1]),
    .snp_valid(sn_v[1]), .snp_cmd(sn_cmd[1]), .snp_addr(sn_a[1]),
    .snp_hit(sn_hit[1]), .snp_supply(sn_sup[1]), .snp_mem_wr(sn_mw[1]), .snp_rdata(sn_d[1])
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int active = -1;

  logic [DW-1:0] mem[256];
  logic [DW-1:0] golden[256];
  int st[2][256];
  int occ[2][NL];

  int log_n;
  int log_cmd[4], log_addr[4], log_sup[4], log_mw[4], log_sh[4];
  logic          pend = 1'b0;
  int            pend_c;
  logic [DW-1:0] pend_d;
  logic          pend_sup, pend_sh;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 37 + 11);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Shared bus: one transaction at a time, snoop in the grant cycle,
  // completion in the following cycle; memory lives here.
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      br_rdy[k] = 1'b0; sn_v[k] = 1'b0; bp_v[k] = 1'b0;
      bp_sup[k] = 1'b0; bp_sh[k] = 1'b0;
    end
    if (rst_n) begin
      for (int k = 0; k < 2; k++)
        if (br_v[k] && k != active) check($sformatf("R12 idle cache %0d bus quiet", k), 1, 0);
      if (pend) begin
        bp_v[pend_c] = 1'b1; bp_d[pend_c] = pend_d;
        bp_sup[pend_c] = pend_sup; bp_sh[pend_c] = pend_sh;
        pend = 1'b0;
      end else begin
        for (int g = 0; g < 2; g++) begin
          if (br_v[g] && g == active) begin
            br_rdy[g] = 1'b1;
            log_cmd[log_n] = int'(br_cmd[g]);
            log_addr[log_n] = int'(br_a[g]);
            log_sup[log_n] = 0; log_mw[log_n] = 0; log_sh[log_n] = 0;
            if (int'(br_cmd[g]) == CWB) begin
              mem[br_a[g]] = br_d[g];
            end else begin
              sn_v[1-g] = 1'b1; sn_cmd[1-g] = br_cmd[g]; sn_a[1-g] = br_a[g];
              #1;
              log_sup[log_n] = int'(sn_sup[1-g]);
              log_mw[log_n] = int'(sn_mw[1-g]);
              log_sh[log_n] = int'(sn_hit[1-g]);
              if (sn_mw[1-g]) mem[br_a[g]] = sn_d[1-g];
              pend_d = sn_sup[1-g] ? sn_d[1-g] : mem[br_a[g]];
              pend_sup = sn_sup[1-g]; pend_sh = sn_hit[1-g];
              pend_c = g; pend = 1'b1;
            end
            if (log_n < 3) log_n++;
          end
        end
      end
    end
  end

  // One processor operation on cache c, checked against the reference model.
  task automatic op(input int c, input bit wr, input int a, input logic [DW-1:0] wd, input string tag);
    int o = 1 - c;
    int idx = a % NL;
    int own, oth, vic, exp_n, lim;
    int ecmd[2], eaddr[2];
    int esup, emw, esh;
    logic [DW-1:0] got;
    bit done;
    own = (occ[c][idx] == a) ? st[c][a] : SI;
    oth = (occ[o][idx] == a) ? st[o][a] : SI;
    vic = occ[c][idx];
    exp_n = 0; esup = 0; emw = 0; esh = 0;
    if (!((!wr && own != SI) || (wr && (own == SE || own == SM)))) begin
      if (own == SI && vic >= 0 && st[c][vic] == SM) begin
        ecmd[0] = CWB; eaddr[0] = vic; exp_n = 1;
      end
      ecmd[exp_n] = !wr ? CRD : (own != SI ? CINV : CRFO);
      eaddr[exp_n] = a;
      esh = int'(oth != SI);
      emw = int'(oth == SM);
      esup = (ecmd[exp_n] == CINV) ? int'(oth == SM) : int'(oth == SM || oth == SE || oth == SR);
      exp_n++;
    end
    log_n = 0;
    active = c;
    @(negedge clk);
    rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = AW'(a); rq_d[c] = wd;
    done = 1'b0; lim = 0;
    while (!done && lim < 50) begin
      #2;
      done = rq_rdy[c];
      @(posedge clk);
      if (!done) @(negedge clk);
      lim++;
    end
    done = 1'b0; lim = 0;
    while (!done && lim < 50) begin
      @(negedge clk);
      rq_v[c] = 1'b0;
      if (rs_v[c]) begin done = 1'b1; got = rs_d[c]; end
      lim++;
    end
    active = -1;
    check({tag, " response seen"}, int'(done), 1);
    check({tag, " bus transaction count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check({tag, " bus command"}, log_cmd[i], ecmd[i]);
      check({tag, " bus address"}, log_addr[i], eaddr[i]);
    end
    if (exp_n > 0 && log_n == exp_n && ecmd[exp_n-1] != CWB) begin
      check({tag, " peer supplied"}, log_sup[exp_n-1], esup);
      check({tag, " memory update"}, log_mw[exp_n-1], emw);
      check({tag, " peer shared"}, log_sh[exp_n-1], esh);
    end
    if (!wr) check({tag, " R13 read data"}, got, golden[a]);
    // model update
    if (vic >= 0 && vic != a) st[c][vic] = SI;
    if (wr) begin
      if (exp_n > 0) st[o][a] = SI;
      st[c][a] = SM;
      golden[a] = wd;
    end else if (own == SI) begin
      st[c][a] = esup ? SR : (esh ? SS : SE);
      if (oth == SM || oth == SE || oth == SR) st[o][a] = SS;
    end
    occ[c][idx] = a;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = init_val(a); golden[a] = init_val(a);
      st[0][a] = SI; st[1][a] = SI;
    end
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < NL; i++) occ[k][i] = -1;
      rq_v[k] = 0; rq_w[k] = 0; rq_a[k] = '0; rq_d[k] = '0;
      br_rdy[k] = 0; bp_v[k] = 0; bp_d[k] = '0; bp_sup[k] = 0; bp_sh[k] = 0;
      sn_v[k] = 0; sn_cmd[k] = '0; sn_a[k] = '0;
    end
    log_n = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check("R1 ready after reset", int'(rq_rdy[k]), 1);
      check("R1 bus idle after reset", int'(br_v[k]), 0);
      check("R1 no response after reset", int'(rs_v[k]), 0);
      check("R1 snoop outputs quiet", int'({sn_hit[k], sn_sup[k], sn_mw[k]}), 0);
    end
    op(0, 0, 'h10, '0,      "R1 R5 cold read to exclusive");
    op(0, 0, 'h10, '0,      "R2 read hit");
    op(0, 1, 'h10, 'hA5A5,  "R3 silent write on exclusive");
    op(1, 0, 'h10, '0,      "R7 R5 dirty intervention to recent");
    op(0, 0, 'h10, '0,      "R2 read hit on shared");
    op(0, 1, 'h10, 'h1234,  "R4 upgrade from shared");
    op(1, 0, 'h10, '0,      "R7 dirty supply again");
    op(1, 1, 'h10, 'h5678,  "R4 upgrade from recent");
    op(0, 1, 'h20, 'h2222,  "R10 write miss");
    op(0, 1, 'h30, 'h3333,  "R11 R10 dirty victim then ownership");
    op(0, 0, 'h20, '0,      "R11 R13 victim writeback then refill");
    op(1, 0, 'h21, '0,      "R5 exclusive fill");
    op(0, 0, 'h21, '0,      "R6 clean intervention");
    op(0, 0, 'h29, '0,      "R5 clean recent evicted");
    op(0, 0, 'h21, '0,      "R9 R5 shared holder no supply");
    op(1, 1, 'h21, 'h4444,  "R4 upgrade invalidates peer");
    op(0, 0, 'h21, '0,      "R7 R13 coherent read after upgrade");
    op(0, 0, 'h42, '0,      "R5 exclusive fill second line");
    op(1, 1, 'h42, 'h6666,  "R8 ownership snoop on exclusive");
    op(0, 0, 'h42, '0,      "R8 R7 dirty owner after ownership");
    op(1, 0, 'h42, '0,      "R2 former owner now shared hit");
    op(0, 1, 'h10, 'h7777,  "R8 R10 ownership snoop on modified");
    op(1, 0, 'h10, '0,      "R13 final coherent read");
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule